// File: doc/BRIEF.md
# Two-Wire Firmware-Download Handshake Sequencer

This block borrows the two open-drain wires of a serial bus (a clock wire and a data wire) for a short, non-bus handshake that asks a target chip to enter its firmware-download mode. A single start pulse runs a fixed, timed sequence on the wires. First both wires rest at configured levels. Next a pair of square waves at different rates runs, one on each wire. The wires then rest at configured levels again while the target's internal clock settles. Last, the pins go back to the ordinary bus controller.

All timing comes from an internal tick at 1 MHz, divided down from the system clock. Each phase length is a parameter counted in ticks, so a short run can use small values.

The pin drives are levels that the pad logic applies open-drain: 1 releases the wire and 0 pulls it low. `bus_sel_o` steers the pin mux outside the block. When it is high the normal bus controller owns the pins, and the two drive outputs carry no meaning. The block has no streaming data path, so every pin is plain control or status.

Top module: `hs_dfu_wave_seq`

## Requirements
- R1: After reset and whenever idle: `bus_sel_o`=1, `busy_o`=0, `done_o`=0, and both drives are 1 (released).
- R2: A `start_i` pulse sampled while idle makes `busy_o`=1 and `bus_sel_o`=0 from the next cycle. For the first `PRE_TICKS` ticks the clock wire then drives `CLK_PRE_LVL` and the data wire drives `DAT_PRE_LVL`.
- R3: One tick occurs every `CLK_PER_TICK` system clocks, counted from the cycle after start is accepted. Outputs change only on tick boundaries while busy.
- R4: During the next `WAVE_TICKS` ticks the clock wire repeats a period of `CLK_RELOAD`+1 ticks. It is high for the first (`CLK_RELOAD`+1)/2 ticks of each period, rounded down, and low for the rest. The defaults 9 give a 100 kHz wave at 50% duty.
- R5: During the same phase the data wire repeats a period of `DAT_RELOAD`+1 ticks. It is high for the first (`DAT_RELOAD`+1)/2 ticks, rounded down. The default 4 gives a 200 kHz wave that is high for 2 of 5 ticks.
- R6: Both wave counters restart together when the wave phase begins, so both wires rise in the first tick of the phase.
- R7: For the following `POST_TICKS` ticks the clock wire drives `CLK_POST_LVL` and the data wire drives `DAT_POST_LVL`.
- R8: When the post-hold ends, `done_o` is high for exactly one cycle. In that same cycle `bus_sel_o` returns to 1 and `busy_o` to 0.
- R9: A `start_i` that arrives while busy is ignored. The sequence timing and levels are unchanged.
- R10: Each hold level is a separate parameter, where 0 means low and 1 means high. The two wires, and the pre-hold and post-hold phases, may differ.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Begin the handshake sequence (honoured only when idle) |
| wire_clk_o | output | 1 | Drive level for the clock wire (1 = released) |
| wire_dat_o | output | 1 | Drive level for the data wire (1 = released) |
| bus_sel_o | output | 1 | 1 = normal bus controller owns the pins, 0 = this block |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse at pin hand-back |

## Verification
The bench builds the block with 4 system clocks per tick and phase lengths of 3, 20 and 2 ticks. These values make every phase boundary, two full clock-wave periods and four data-wave periods reachable in about a hundred cycles. The hold levels are set unequally (clock 0 then 1, data 1 then 0), so a swapped wire or a swapped pre/post level is visible. The reload values keep their defaults, which exercises the uneven duty of the faster wave.

// File: rtl/hs_dfu_pkg.sv
package hs_dfu_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_PRE  = 2'd1,
    PH_WAVE = 2'd2,
    PH_POST = 2'd3
  } phase_e;
endpackage

// File: rtl/hs_tick_gen.sv
module hs_tick_gen #(
  parameter int CLK_PER_TICK = 48
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic run_i,
  output logic tick_o
);
  localparam int PW = (CLK_PER_TICK > 2) ? $clog2(CLK_PER_TICK) : 1;
  localparam logic [PW-1:0] LAST = PW'(CLK_PER_TICK - 1);

  logic [PW-1:0] div_q;

  always_ff @(posedge clk_i) begin
    if (rst_i || !run_i) div_q <= '0;
    else if (div_q == LAST) div_q <= '0;
    else div_q <= div_q + 1'b1;
  end

  assign tick_o = run_i && (div_q == LAST);
endmodule

// File: rtl/hs_phase_seq.sv
module hs_phase_seq
  import hs_dfu_pkg::*;
#(
  parameter int PRE_TICKS  = 5000,
  parameter int WAVE_TICKS = 50000,
  parameter int POST_TICKS = 10000
) (
  input  logic   clk_i,
  input  logic   rst_i,
  input  logic   start_i,
  input  logic   tick_i,
  output phase_e phase_o,
  output logic   done_o
);
  localparam int MAX_A = (PRE_TICKS > WAVE_TICKS) ? PRE_TICKS : WAVE_TICKS;
  localparam int MAX_D = (MAX_A > POST_TICKS) ? MAX_A : POST_TICKS;
  localparam int DW    = $clog2(MAX_D + 1);

  phase_e        phase_q;
  logic [DW-1:0] dur_q;
  logic [DW-1:0] last_cnt;
  logic          at_end;

  always_comb begin
    unique case (phase_q)
      PH_PRE:  last_cnt = DW'(PRE_TICKS - 1);
      PH_WAVE: last_cnt = DW'(WAVE_TICKS - 1);
      PH_POST: last_cnt = DW'(POST_TICKS - 1);
      default: last_cnt = '0;
    endcase
  end

  assign at_end = tick_i && (dur_q == last_cnt);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      phase_q <= PH_IDLE;
      dur_q   <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (phase_q == PH_IDLE) begin
        dur_q <= '0;
        if (start_i) phase_q <= PH_PRE;
      end else if (at_end) begin
        dur_q <= '0;
        unique case (phase_q)
          PH_PRE:  phase_q <= PH_WAVE;
          PH_WAVE: phase_q <= PH_POST;
          default: begin
            phase_q <= PH_IDLE;
            done_o  <= 1'b1;
          end
        endcase
      end else if (tick_i) begin
        dur_q <= dur_q + 1'b1;
      end
    end
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/hs_sqwave.sv
module hs_sqwave #(
  parameter int RELOAD = 9
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic run_i,
  input  logic tick_i,
  output logic wave_o
);
  localparam int CW = (RELOAD > 1) ? $clog2(RELOAD + 1) : 1;
  localparam logic [CW-1:0] TOP     = CW'(RELOAD);
  localparam logic [CW-1:0] HI_TICK = CW'((RELOAD + 1) / 2);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i || !run_i) cnt_q <= '0;
    else if (tick_i) cnt_q <= (cnt_q == TOP) ? '0 : cnt_q + 1'b1;
  end

  assign wave_o = (cnt_q < HI_TICK);
endmodule

// File: rtl/hs_dfu_wave_seq.sv
module hs_dfu_wave_seq
  import hs_dfu_pkg::*;
#(
  parameter int   CLK_PER_TICK = 48,
  parameter int   PRE_TICKS    = 5000,
  parameter int   WAVE_TICKS   = 50000,
  parameter int   POST_TICKS   = 10000,
  parameter int   CLK_RELOAD   = 9,
  parameter int   DAT_RELOAD   = 4,
  parameter logic CLK_PRE_LVL  = 1'b0,
  parameter logic DAT_PRE_LVL  = 1'b0,
  parameter logic CLK_POST_LVL = 1'b0,
  parameter logic DAT_POST_LVL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic start_i,
  output logic wire_clk_o,
  output logic wire_dat_o,
  output logic bus_sel_o,
  output logic busy_o,
  output logic done_o
);
  phase_e phase;
  logic   tick;
  logic   wave_run;
  logic   clk_wave, dat_wave;

  assign busy_o   = (phase != PH_IDLE);
  assign wave_run = (phase == PH_WAVE);

  hs_tick_gen #(.CLK_PER_TICK(CLK_PER_TICK)) u_tick (
    .clk_i(clk_i), .rst_i(rst_i), .run_i(busy_o), .tick_o(tick)
  );

  hs_phase_seq #(
    .PRE_TICKS(PRE_TICKS), .WAVE_TICKS(WAVE_TICKS), .POST_TICKS(POST_TICKS)
  ) u_seq (
    .clk_i(clk_i), .rst_i(rst_i), .start_i(start_i), .tick_i(tick),
    .phase_o(phase), .done_o(done_o)
  );

  hs_sqwave #(.RELOAD(CLK_RELOAD)) u_clk_wave (
    .clk_i(clk_i), .rst_i(rst_i), .run_i(wave_run), .tick_i(tick), .wave_o(clk_wave)
  );

  hs_sqwave #(.RELOAD(DAT_RELOAD)) u_dat_wave (
    .clk_i(clk_i), .rst_i(rst_i), .run_i(wave_run), .tick_i(tick), .wave_o(dat_wave)
  );

  always_comb begin
    unique case (phase)
      PH_PRE:  begin wire_clk_o = CLK_PRE_LVL;  wire_dat_o = DAT_PRE_LVL;  end
      PH_WAVE: begin wire_clk_o = clk_wave;     wire_dat_o = dat_wave;     end
      PH_POST: begin wire_clk_o = CLK_POST_LVL; wire_dat_o = DAT_POST_LVL; end
      default: begin wire_clk_o = 1'b1;         wire_dat_o = 1'b1;         end
    endcase
  end

  assign bus_sel_o = !busy_o;
endmodule

// File: rtl/hs_dfu_wave_seq_chk.sv
module hs_dfu_wave_seq_chk (
  input logic clk_i,
  input logic rst_i,
  input logic start_i,
  input logic wire_clk_o,
  input logic wire_dat_o,
  input logic bus_sel_o,
  input logic busy_o,
  input logic done_o,
  input logic tick
);
  // R8: done is a single-cycle pulse
  a_r8_done_single: assert property (@(posedge clk_i) disable iff (rst_i)
    done_o |=> !done_o);

  // R8: pins handed back in the done cycle
  a_r8_done_release: assert property (@(posedge clk_i) disable iff (rst_i)
    done_o |-> (bus_sel_o && !busy_o));

  // R2: an idle start makes the block busy
  a_r2_start_accept: assert property (@(posedge clk_i) disable iff (rst_i)
    (start_i && !busy_o) |=> (busy_o && !bus_sel_o));

  // R9: busy only begins from a start request
  a_r9_busy_needs_start: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(busy_o) |-> $past(start_i));

  // R3: drives change only after a tick while busy
  a_r3_stable_off_tick: assert property (@(posedge clk_i) disable iff (rst_i)
    (busy_o && $past(busy_o) && !$past(tick)) |-> ($stable(wire_clk_o) && $stable(wire_dat_o)));

  // R1: idle drives are released
  a_r1_idle_released: assert property (@(posedge clk_i) disable iff (rst_i)
    !busy_o |-> (wire_clk_o && wire_dat_o && bus_sel_o));
endmodule

bind hs_dfu_wave_seq hs_dfu_wave_seq_chk i_chk (
  .clk_i(clk_i), .rst_i(rst_i), .start_i(start_i),
  .wire_clk_o(wire_clk_o), .wire_dat_o(wire_dat_o),
  .bus_sel_o(bus_sel_o), .busy_o(busy_o), .done_o(done_o), .tick(tick)
);

// File: tb/test_hs_dfu_wave_seq.sv
module test_hs_dfu_wave_seq;
  localparam int T      = 4;
  localparam int NPRE   = 3;
  localparam int NWAVE  = 20;
  localparam int NPOST  = 2;
  localparam int CRL    = 9;
  localparam int DRL    = 4;
  localparam bit CPRE   = 1'b0;
  localparam bit DPRE   = 1'b1;
  localparam bit CPOST  = 1'b1;
  localparam bit DPOST  = 1'b0;
  localparam int NTOT   = NPRE + NWAVE + NPOST;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic wclk, wdat, bsel, busy, done;
  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  hs_dfu_wave_seq #(
    .CLK_PER_TICK(T), .PRE_TICKS(NPRE), .WAVE_TICKS(NWAVE), .POST_TICKS(NPOST),
    .CLK_RELOAD(CRL), .DAT_RELOAD(DRL),
    .CLK_PRE_LVL(CPRE), .DAT_PRE_LVL(DPRE), .CLK_POST_LVL(CPOST), .DAT_POST_LVL(DPOST)
  ) i_hs_dfu_wave_seq (
    .clk_i(clk), .rst_i(rst), .start_i(start),
    .wire_clk_o(wclk), .wire_dat_o(wdat), .bus_sel_o(bsel), .busy_o(busy), .done_o(done)
  );

  task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: {clk,dat,sel,busy,done} actual=%b expected=%b",
               req, cyc, act, exp);
    end
  endtask

  // expected outputs k cycles after the start edge
  task automatic expect_at(input int k, output logic [4:0] exp, output string req);
    int tk;
    int j;
    tk = k / T;
    if (tk < NPRE) begin
      exp = {CPRE, DPRE, 1'b0, 1'b1, 1'b0}; req = "R2/R10 pre-hold";
    end else if (tk < NPRE + NWAVE) begin
      j = tk - NPRE;
      exp = {((j % (CRL + 1)) < (CRL + 1) / 2), ((j % (DRL + 1)) < (DRL + 1) / 2),
             1'b0, 1'b1, 1'b0};
      req = (j == 0) ? "R6 aligned start" : "R4/R5 waves, R3 tick";
    end else if (tk < NTOT) begin
      exp = {CPOST, DPOST, 1'b0, 1'b1, 1'b0}; req = "R7/R10 post-hold";
    end else if (k == NTOT * T) begin
      exp = 5'b11110 ^ 5'b00011; req = "R8 done pulse";
    end else begin
      exp = 5'b11100; req = "R8/R1 idle after done";
    end
  endtask

  task automatic run_seq(input int noise_at);
    logic [4:0] e;
    string r;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k <= NTOT * T + 2; k++) begin
      expect_at(k, e, r);
      check(r, {wclk, wdat, bsel, busy, done}, e);
      start = (k == noise_at);
      @(negedge clk);
    end
    start = 1'b0;
  endtask

  task automatic t_reset_state();
    check("R1 reset state", {wclk, wdat, bsel, busy, done}, 5'b11100);
  endtask

  task automatic t_plain_run();
    run_seq(-1);
  endtask

  task automatic t_start_while_busy();
    // R9: start pulses during pre-hold and mid-wave must change nothing
    run_seq(2);
    run_seq(NPRE * T + 30);
  endtask

  task automatic t_mid_reset();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (NPRE * T + 5) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 idle after reset mid-run", {wclk, wdat, bsel, busy, done}, 5'b11100);
    repeat (3) @(negedge clk);
    check("R9 no spontaneous restart", {wclk, wdat, bsel, busy, done}, 5'b11100);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset_state();
    t_plain_run();
    t_start_while_busy();
    t_mid_reset();
    t_plain_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule